// File: doc/BRIEF.md
# Register-Write Command Stream Executor

This block runs a list of register-write instructions that software has placed in memory, so a batch of register updates reaches the local register bus without the processor having to issue each write. Software sets the enable bit in the control register, writes the head pointer with the first instruction's byte address, and then writes the tail pointer. The tail write launches execution. The engine reads one 64-bit slot at a time from a simple memory-read port, decodes it, and issues the resulting writes on a register-write port. The busy bit stays high until the fetch address reaches the tail.

Two instruction kinds exist. A direct write carries one value, a 20-bit register offset and four byte enables. An indexed write carries a count N and an offset, followed by N packed values and a zero pad dword when N is odd. It produces N writes to the same offset. A slot whose opcode is zero is skipped, so the zero fill between the last instruction and a rounded-up tail does no harm. An unknown nonzero opcode stops the engine and sets a sticky error bit. The engine has no read operation of any kind.

Top module: `regwr_stream`

## Requirements
- R1: Control/status space at csr_addr 0 (control), 1 (head pointer), 2 (tail pointer). Control bit 0 is a read/write enable, bit 1 reads busy, bit 2 reads the sticky error and is cleared by writing 1 to it. Every register and output reads 0 after reset.
- R2: A tail-pointer write while enable is 1 and the engine is idle raises busy in the next cycle and starts fetching at the head pointer rounded down to 8 bytes. With enable at 0 the tail value is stored but nothing starts.
- R3: The engine requests 64-bit slots at ascending 8-byte-aligned addresses, one slot per request. In each slot the lower dword is bits [31:0] and the upper dword is bits [63:32]. Busy clears, with the fetch address equal to the tail, once the fetch address reaches the tail. When head equals tail, no fetch is made.
- R4: A direct write is a slot whose upper dword has opcode 0x01 in [31:24], byte enables in [23:20] and the offset in [19:0]. The lower dword is the value. It produces one register write with exactly those byte enables.
- R5: An indexed write is a slot whose upper dword has opcode 0x09 in [31:24] and the offset in [19:0]. Its lower dword is the count N. The following slots carry the N values, lower dword first and then upper dword, with a zero pad dword when N is odd. It produces N writes to that offset, in order, with all four byte enables set.
- R6: An indexed write with count 0 produces no write, and the next slot is decoded as an instruction.
- R7: A slot with opcode 0x00 produces no write and execution continues with the next slot.
- R8: A slot with any other opcode sets the error bit, clears busy in the same cycle, and produces no write. Nothing after it is fetched.
- R9: Head-pointer and tail-pointer writes that arrive while busy is 1 are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| csr_we | input | 1 | Control/status write strobe |
| csr_addr | input | 2 | Control/status register select |
| csr_wdata | input | 32 | Control/status write data |
| csr_rdata | output | 32 | Control/status read data, combinational from csr_addr |
| busy | output | 1 | Engine executing (same as control bit 1) |
| mem_req | output | 1 | Slot read request |
| mem_addr | output | AW | Byte address of the requested slot |
| mem_rvalid | input | 1 | Slot data valid |
| mem_rdata | input | 64 | Slot data |
| rw_en | output | 1 | Register write strobe, one cycle per write |
| rw_offset | output | 20 | Register offset |
| rw_data | output | 32 | Register write value |
| rw_be | output | 4 | Byte enables |

## Verification
The race that matters here is a pointer write landing in the very cycle in which the engine reaches the tail and drops busy. The bench provokes it by re-launching a program and then driving a head-pointer write in every cycle in which busy is seen high, up to and including the last busy cycle. It judges the result by reading the head pointer back after the run: it must still hold the launch value. The write log must also be unchanged from a clean run. A further head write once the engine is idle must then be accepted.

// File: rtl/rws_pkg.sv
package rws_pkg;

    localparam logic [7:0] OP_SKIP    = 8'h00;
    localparam logic [7:0] OP_DIRECT  = 8'h01;
    localparam logic [7:0] OP_INDEXED = 8'h09;

    localparam logic [1:0] CSR_CTRL = 2'd0;
    localparam logic [1:0] CSR_HEAD = 2'd1;
    localparam logic [1:0] CSR_TAIL = 2'd2;

    localparam int CTRL_EN_BIT   = 0;
    localparam int CTRL_BUSY_BIT = 1;
    localparam int CTRL_ERR_BIT  = 2;

    localparam int OFFS_W = 20;
    localparam int SLOT_BYTES = 8;

    typedef enum logic [1:0] {
        K_SKIP,
        K_DIRECT,
        K_INDEXED,
        K_BAD
    } slot_kind_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_REQ,
        ST_WAIT,
        ST_HI
    } seq_state_e;

    typedef struct packed {
        slot_kind_e          kind;
        logic [OFFS_W-1:0]   offs;
        logic [3:0]          be;
        logic [31:0]         lo;
        logic [31:0]         hi;
    } slot_dec_t;

    typedef struct packed {
        logic                en;
        logic [OFFS_W-1:0]   offs;
        logic [31:0]         data;
        logic [3:0]          be;
    } regwr_t;

    function automatic slot_kind_e op_kind(input logic [7:0] op);
        case (op)
            OP_SKIP:    return K_SKIP;
            OP_DIRECT:  return K_DIRECT;
            OP_INDEXED: return K_INDEXED;
            default:    return K_BAD;
        endcase
    endfunction

endpackage

// File: rtl/rws_decode.sv
module rws_decode
    import rws_pkg::*;
(
    input  logic [63:0] slot,
    output slot_dec_t   dec
);
    always_comb begin
        dec.kind = op_kind(slot[63:56]);
        dec.be   = slot[55:52];
        dec.offs = slot[32+OFFS_W-1:32];
        dec.lo   = slot[31:0];
        dec.hi   = slot[63:32];
    end
endmodule

// File: rtl/rws_csr.sv
module rws_csr
    import rws_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          csr_we,
    input  logic [1:0]    csr_addr,
    input  logic [31:0]   csr_wdata,
    input  logic          busy,
    input  logic          err_set,
    output logic          enable,
    output logic          err,
    output logic [AW-1:0] head,
    output logic [AW-1:0] tail,
    output logic          launch,
    output logic [31:0]   csr_rdata
);
    logic wr_ctrl, wr_head, wr_tail;
    logic unused_wbits;

    assign wr_ctrl = csr_we && (csr_addr == CSR_CTRL);
    assign wr_head = csr_we && (csr_addr == CSR_HEAD);
    assign wr_tail = csr_we && (csr_addr == CSR_TAIL);
    assign launch  = wr_tail && enable && !busy;
    assign unused_wbits = ^csr_wdata[31:AW];

    always_ff @(posedge clk) begin
        if (rst) begin
            enable <= 1'b0;
            err    <= 1'b0;
            head   <= '0;
            tail   <= '0;
        end else begin
            if (wr_ctrl) enable <= csr_wdata[CTRL_EN_BIT];
            if (err_set) err <= 1'b1;
            else if (wr_ctrl && csr_wdata[CTRL_ERR_BIT]) err <= 1'b0;
            if (wr_head && !busy) head <= csr_wdata[AW-1:0];
            if (wr_tail && !busy) tail <= csr_wdata[AW-1:0];
        end
    end

    always_comb begin
        csr_rdata = '0;
        case (csr_addr)
            CSR_CTRL: begin
                csr_rdata[CTRL_EN_BIT]   = enable;
                csr_rdata[CTRL_BUSY_BIT] = busy;
                csr_rdata[CTRL_ERR_BIT]  = err;
            end
            CSR_HEAD: csr_rdata = 32'(head);
            CSR_TAIL: csr_rdata = 32'(tail);
            default:  csr_rdata = '0;
        endcase
    end

    p_head_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(head));
    p_tail_frozen_r9: assert property (@(posedge clk) disable iff (rst)
        busy |=> $stable(tail));
    p_no_start_disabled_r2: assert property (@(posedge clk) disable iff (rst)
        (!enable && !busy) |=> !busy);
endmodule

// File: rtl/rws_seq.sv
module rws_seq
    import rws_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          launch,
    input  logic [AW-1:0] head,
    input  logic [AW-1:0] tail,
    input  logic          mem_rvalid,
    input  slot_dec_t     dec,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    output logic          err_set,
    output regwr_t        wr
);
    localparam logic [AW-1:0] STEP = AW'(SLOT_BYTES);
    localparam logic [AW-1:0] ALIGN_MASK = ~(AW'(SLOT_BYTES - 1));

    seq_state_e    state;
    logic [AW-1:0] fa;
    logic [AW-1:0] head_al, tail_al;
    logic          at_tail;
    logic          in_data;
    logic [31:0]   remaining;
    logic [OFFS_W-1:0] offs_q;
    logic [31:0]   hi_q;

    assign head_al  = head & ALIGN_MASK;
    assign tail_al  = tail & ALIGN_MASK;
    assign at_tail  = (fa == tail_al);
    assign busy     = (state != ST_IDLE);
    assign mem_req  = (state == ST_REQ) && !at_tail;
    assign mem_addr = fa;
    assign err_set  = (state == ST_WAIT) && mem_rvalid && !in_data
                      && (dec.kind == K_BAD);

    always_ff @(posedge clk) begin
        if (rst) begin
            state     <= ST_IDLE;
            fa        <= '0;
            in_data   <= 1'b0;
            remaining <= '0;
            offs_q    <= '0;
            hi_q      <= '0;
            wr        <= '0;
        end else begin
            wr.en <= 1'b0;
            case (state)
                ST_IDLE: begin
                    if (launch) begin
                        fa        <= head_al;
                        in_data   <= 1'b0;
                        remaining <= '0;
                        state     <= ST_REQ;
                    end
                end
                ST_REQ: begin
                    state <= at_tail ? ST_IDLE : ST_WAIT;
                end
                ST_WAIT: begin
                    if (mem_rvalid) begin
                        fa <= fa + STEP;
                        if (in_data) begin
                            wr <= '{en: 1'b1, offs: offs_q, data: dec.lo, be: 4'hF};
                            if (remaining >= 32'd2) begin
                                remaining <= remaining - 32'd2;
                                hi_q      <= dec.hi;
                                in_data   <= (remaining != 32'd2);
                                state     <= ST_HI;
                            end else begin
                                remaining <= '0;
                                in_data   <= 1'b0;
                                state     <= ST_REQ;
                            end
                        end else begin
                            case (dec.kind)
                                K_DIRECT: begin
                                    wr <= '{en: 1'b1, offs: dec.offs, data: dec.lo, be: dec.be};
                                    state <= ST_REQ;
                                end
                                K_INDEXED: begin
                                    offs_q    <= dec.offs;
                                    remaining <= dec.lo;
                                    in_data   <= (dec.lo != 32'd0);
                                    state     <= ST_REQ;
                                end
                                K_BAD:   state <= ST_IDLE;
                                default: state <= ST_REQ;
                            endcase
                        end
                    end
                end
                ST_HI: begin
                    wr    <= '{en: 1'b1, offs: offs_q, data: hi_q, be: 4'hF};
                    state <= ST_REQ;
                end
                default: state <= ST_IDLE;
            endcase
        end
    end

    p_fetch_aligned_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> (mem_addr[2:0] == 3'b000));
    p_pack_hi_full_be_r5: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HI) |=> (wr.en && wr.be == 4'hF));
    p_stop_at_tail_r3: assert property (@(posedge clk) disable iff (rst)
        $fell(busy) |-> (at_tail || $past(err_set)));
    p_bad_no_write_r8: assert property (@(posedge clk) disable iff (rst)
        err_set |=> !wr.en && !busy);
endmodule

// File: rtl/regwr_stream.sv
module regwr_stream
    import rws_pkg::*;
#(
    parameter int AW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          csr_we,
    input  logic [1:0]    csr_addr,
    input  logic [31:0]   csr_wdata,
    output logic [31:0]   csr_rdata,
    output logic          busy,
    output logic          mem_req,
    output logic [AW-1:0] mem_addr,
    input  logic          mem_rvalid,
    input  logic [63:0]   mem_rdata,
    output logic          rw_en,
    output logic [19:0]   rw_offset,
    output logic [31:0]   rw_data,
    output logic [3:0]    rw_be
);
    logic          enable, err, launch, err_set;
    logic [AW-1:0] head, tail;
    slot_dec_t     dec;
    regwr_t        wr;

    rws_csr #(.AW(AW)) u_csr (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .busy(busy), .err_set(err_set),
        .enable(enable), .err(err), .head(head), .tail(tail),
        .launch(launch), .csr_rdata(csr_rdata)
    );

    rws_decode u_dec (.slot(mem_rdata), .dec(dec));

    rws_seq #(.AW(AW)) u_seq (
        .clk(clk), .rst(rst), .launch(launch), .head(head), .tail(tail),
        .mem_rvalid(mem_rvalid), .dec(dec), .busy(busy), .mem_req(mem_req),
        .mem_addr(mem_addr), .err_set(err_set), .wr(wr)
    );

    assign rw_en     = wr.en;
    assign rw_offset = wr.offs;
    assign rw_data   = wr.data;
    assign rw_be     = wr.be;

    p_write_in_run_r4: assert property (@(posedge clk) disable iff (rst)
        rw_en |-> busy);
    p_err_idle_r8: assert property (@(posedge clk) disable iff (rst)
        $rose(err) |-> !busy);
    p_req_in_run_r3: assert property (@(posedge clk) disable iff (rst)
        mem_req |-> busy && enable);
endmodule

// File: tb/regwr_stream_test.sv
module regwr_stream_test;
    localparam int AW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          csr_we = 1'b0;
    logic [1:0]    csr_addr = 2'd0;
    logic [31:0]   csr_wdata = '0;
    logic [31:0]   csr_rdata;
    logic          busy;
    logic          mem_req;
    logic [AW-1:0] mem_addr;
    logic          mem_rvalid = 1'b0;
    logic [63:0]   mem_rdata = '0;
    logic          rw_en;
    logic [19:0]   rw_offset;
    logic [31:0]   rw_data;
    logic [3:0]    rw_be;

    int checks = 0;
    int errors = 0;
    int n_log = 0;
    int n_req = 0;
    logic [55:0] log_q [0:63];
    logic [63:0] mem [0:127];

    // expected writes of the main program: offset(20) data(32) be(4)
    localparam logic [55:0] EXP_TAB [0:6] = '{
        56'h01234_A5A50001_3,
        56'h00400_11111111_F,
        56'h00400_22222222_F,
        56'h00400_33333333_F,
        56'h00800_BBBB0001_F,
        56'h00800_BBBB0002_F,
        56'hFFFFF_DEADBEEF_F
    };

    always #5 clk = ~clk;

    regwr_stream #(.AW(AW)) uut (
        .clk(clk), .rst(rst), .csr_we(csr_we), .csr_addr(csr_addr),
        .csr_wdata(csr_wdata), .csr_rdata(csr_rdata), .busy(busy),
        .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
        .mem_rdata(mem_rdata), .rw_en(rw_en), .rw_offset(rw_offset),
        .rw_data(rw_data), .rw_be(rw_be)
    );

    always @(posedge clk) begin
        mem_rvalid <= mem_req;
        mem_rdata  <= mem[mem_addr[9:3]];
    end

    always @(negedge clk) begin
        if (rw_en && n_log < 64) begin
            log_q[n_log] = {rw_offset, rw_data, rw_be};
            n_log++;
        end
        if (mem_req) n_req++;
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic csr_wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        csr_we = 1'b1; csr_addr = a; csr_wdata = d;
        @(negedge clk);
        csr_we = 1'b0;
    endtask

    task automatic csr_rd(input logic [1:0] a, output logic [31:0] d);
        csr_addr = a;
        #1;
        d = csr_rdata;
    endtask

    task automatic wait_idle();
        int n = 0;
        while (busy && n < 2000) begin
            @(negedge clk);
            n++;
        end
    endtask

    task automatic put(input int addr, input logic [31:0] hi, input logic [31:0] lo);
        mem[addr[9:3]] = {hi, lo};
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%h expected=%h", 0, 1);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [31:0] r;
        int base;
        int req_base;

        for (int i = 0; i < 128; i++) mem[i] = '0;
        // main program at 0x000, tail 0x040
        put(32'h000, 32'h0130_1234, 32'hA5A5_0001);
        put(32'h008, 32'h0900_0400, 32'd3);
        put(32'h010, 32'h2222_2222, 32'h1111_1111);
        put(32'h018, 32'h0000_0000, 32'h3333_3333);
        put(32'h020, 32'h0000_0000, 32'h0000_0000);
        put(32'h028, 32'h0900_0800, 32'd2);
        put(32'h030, 32'hBBBB_0002, 32'hBBBB_0001);
        put(32'h038, 32'h01FF_FFFF, 32'hDEAD_BEEF);
        // bad opcode program at 0x100
        put(32'h100, 32'h0500_0010, 32'h0000_0000);
        put(32'h108, 32'h01F0_0020, 32'h0000_0077);
        // count-zero and count-one program at 0x200
        put(32'h200, 32'h0900_0030, 32'd0);
        put(32'h208, 32'h0900_0040, 32'd1);
        put(32'h210, 32'h0000_0000, 32'h4444_4444);

        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        csr_rd(2'd0, r); chk(r == 0, "R1 ctrl after reset", r, 0);
        csr_rd(2'd1, r); chk(r == 0, "R1 head after reset", r, 0);
        chk(!rw_en && !mem_req && !busy, "R1 outputs after reset",
            {rw_en, mem_req, busy}, 0);

        // R2 tail write with enable clear stores but does not start
        req_base = n_req;
        csr_wr(2'd1, 32'h0);
        csr_wr(2'd2, 32'h40);
        repeat (3) @(negedge clk);
        chk(!busy && n_req == req_base, "R2 no start when disabled",
            {busy, 32'(n_req - req_base)}, 0);
        csr_rd(2'd2, r); chk(r == 32'h40, "R1 tail stored", r, 32'h40);

        csr_wr(2'd0, 32'h1);
        csr_rd(2'd0, r); chk(r == 32'h1, "R1 enable readback", r, 1);

        // main program
        base = n_log;
        csr_wr(2'd2, 32'h40);
        chk(busy, "R2 busy one cycle after tail write", busy, 1);
        wait_idle();
        chk(n_log - base == 7, "R5 R7 write count main program", n_log - base, 7);
        for (int i = 0; i < 7; i++)
            chk(log_q[base + i] == EXP_TAB[i], "R4 R5 R7 write sequence",
                log_q[base + i], EXP_TAB[i]);
        chk(mem_addr == 16'h40 && !busy, "R3 stop at tail", mem_addr, 16'h40);

        // R8 unknown opcode
        base = n_log;
        csr_wr(2'd1, 32'h100);
        csr_wr(2'd2, 32'h140);
        wait_idle();
        csr_rd(2'd0, r);
        chk(r == 32'h5, "R8 error set busy clear", r, 32'h5);
        chk(n_log == base, "R8 no write after bad opcode", n_log - base, 0);
        chk(mem_addr == 16'h108, "R8 fetch halted", mem_addr, 16'h108);
        csr_wr(2'd0, 32'h5);
        csr_rd(2'd0, r); chk(r == 32'h1, "R1 error write-one clear", r, 1);

        // R6 count zero, then count one with pad
        base = n_log;
        csr_wr(2'd1, 32'h200);
        csr_wr(2'd2, 32'h218);
        wait_idle();
        chk(n_log - base == 1, "R6 count zero gives no write", n_log - base, 1);
        chk(log_q[base] == 56'h00040_44444444_F, "R5 R6 single value",
            log_q[base], 56'h00040_44444444_F);

        // R3 head equal to tail
        base = n_log;
        req_base = n_req;
        csr_wr(2'd1, 32'h300);
        csr_wr(2'd2, 32'h300);
        wait_idle();
        chk(n_log == base && n_req == req_base && !busy, "R3 empty range",
            32'(n_req - req_base), 0);

        // R9 pointer writes during a run, including the final busy cycle
        csr_wr(2'd1, 32'h0);
        base = n_log;
        csr_wr(2'd2, 32'h40);
        while (busy) begin
            csr_we = 1'b1; csr_addr = 2'd1; csr_wdata = 32'h300;
            @(negedge clk);
        end
        csr_we = 1'b0;
        csr_rd(2'd1, r); chk(r == 32'h0, "R9 head write ignored while busy", r, 0);
        chk(n_log - base == 7, "R9 run undisturbed", n_log - base, 7);
        csr_wr(2'd1, 32'h300);
        csr_rd(2'd1, r); chk(r == 32'h300, "R9 head write accepted when idle", r, 32'h300);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule